// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Register

This block turns characters written by a host into asynchronous serial frames on one output line. The line rests high. Each frame is a low start bit, the character least significant bit first, an optional parity bit and one or two high stop bits. All bit timing comes from a clock-enable input that pulses sixteen times per bit period. Baud generation lies outside the block.

A holding register sits in front of the shift register. The host writes the next character while the current one is still on the line. When the current frame's last stop bit ends, the waiting character starts on the very next bit period, so frames run back to back with no idle bit between them. The data length (7 or 8 bits), the parity (none, even or odd) and the stop-bit count (1 or 2) are run-time inputs. Each character takes them at the moment it moves into the shift register. The block has no receive path, so the receiver elsewhere works independently for full duplex.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txOut` is 1. After reset, `holdEmpty` is 1 and `txEnd` is 1.
- R2: A frame begins with one start bit at 0. Every bit of the frame, start bit included, stays on `txOut` for exactly 16 pulses of `tick16`.
- R3: The data bits follow the start bit least significant bit first. There are 8 of them when `cfgEightBits`=1 and 7 (`wrData[6:0]`) when it is 0. In 7-bit mode `wrData[7]` is not sent.
- R4: When `cfgParityEn`=1, one parity bit follows the data. `cfgParityOdd`=0 selects even parity, so the total count of ones in the data and parity bits is even. `cfgParityOdd`=1 makes that count odd. When `cfgParityEn`=0, no parity bit is sent.
- R5: The frame ends with stop bits at 1: two of them when `cfgTwoStop`=1 and one when it is 0.
- R6: A write (`wrEn`=1 while `holdEmpty`=1) captures `wrData` and clears `holdEmpty` on the next clock. If no frame is being sent, the character moves into the shift register on the following clock and `holdEmpty` returns to 1. If a frame is being sent, the move waits until that frame ends.
- R7: A write while `holdEmpty`=0 is ignored. The held character is not changed and the ignored character is never sent.
- R8: If the holding register is full when the last stop bit of a frame ends, the start bit of the next frame follows directly, with no idle bit in between.
- R9: `txEnd` is 1 only when no frame is being sent and the holding register is empty. During a frame it is 0.
- R10: The configuration inputs are sampled when a character moves into the shift register. Changing them afterwards does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| cfgEightBits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityEn | input | 1 | 1: append a parity bit |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgTwoStop | input | 1 | 1: two stop bits, 0: one |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to write |
| holdEmpty | output | 1 | Holding register can accept a character |
| txEnd | output | 1 | Transmitter idle with nothing waiting |
| txOut | output | 1 | Serial output line |

## Verification
The hardest situation to reach is a frame handover: the holding register is full just as the last stop bit ends, the configuration has changed since the previous load, and a further write arrives while the register is full. The bench writes the first character, waits for `holdEmpty` to show that the character has moved into the shift register, then switches the configuration, writes a second character and tries a third. A monitor that counts `tick16` pulses checks that the second start bit follows the last stop bit without a gap, that each frame keeps its own format, and that the third character never appears. Around this, a sweep over all sixteen configurations with several data patterns checks every bit of every frame, sample by sample.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // move held character into the shift register
    logic shift;  // advance to the next bit of the frame
  } txStrobe_t;
endpackage

// File: rtl/serial_frame_tx_dp.sv
module serial_frame_tx_dp
  import serial_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAME_W = 1 + DATA_W + 1 + 2,
  parameter int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgEightBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              lastBit,
  output logic              txOut
);
  logic [DATA_W-1:0]  holdData;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] frameImg;
  logic [CNT_W-1:0]   frameLen;
  logic [CNT_W-1:0]   nData;
  logic               parBit;

  // frame image: start, data LSB first, optional parity, ones beyond
  always_comb begin
    nData  = cfgEightBits ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    parBit = cfgParityOdd;
    frameImg = '1;
    frameImg[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nData) begin
        frameImg[i+1] = holdData[i];
        parBit = parBit ^ holdData[i];
      end
    end
    for (int j = 1; j < FRAME_W; j++) begin
      if (cfgParityEn && (CNT_W'(j) == nData + CNT_W'(1))) frameImg[j] = parBit;
    end
    frameLen = CNT_W'(2) + nData + CNT_W'(cfgParityEn) + CNT_W'(cfgTwoStop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdData <= '0;
      holdFull <= 1'b0;
    end else if (strobe.load) begin
      holdFull <= 1'b0;
    end else if (wrEn && !holdFull) begin
      holdData <= wrData;
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      shiftReg <= frameImg;
      bitsLeft <= frameLen;
    end else if (strobe.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  assign lastBit = (bitsLeft == CNT_W'(1));
  assign txOut   = shiftReg[0];

  // R6: an accepted write fills the holding register
  assert_hold_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !holdFull) |=> holdFull);
  // R7: a write into a full register leaves the held character alone
  assert_ignore_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && holdFull) |=> (holdData == $past(holdData)));
  // R2: a load puts the low start bit on the line
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> !txOut);
endmodule

// File: rtl/serial_frame_tx_ctrl.sv
module serial_frame_tx_ctrl
  import serial_frame_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_W = $clog2(OVERSAMPLE)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick16,
  input  logic      holdFull,
  input  logic      lastBit,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);

  logic [TICK_W-1:0] tickCnt;
  logic              bitDone;

  assign bitDone = busy && tick16 && (tickCnt == TICK_LAST);

  always_comb begin
    strobe = '0;
    if (!busy) begin
      strobe.load = holdFull;
    end else if (bitDone) begin
      if (lastBit) strobe.load = holdFull;
      else         strobe.shift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (strobe.load) begin
      busy <= 1'b1;
    end else if (bitDone && lastBit) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tickCnt <= '0;
    else if (!busy)  tickCnt <= '0;
    else if (tick16) tickCnt <= tickCnt + TICK_W'(1);
  end

  // R2: bit timing advances only on the 16x enable
  assert_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> $stable(tickCnt));
  // R8: a full holding register at frame end keeps the line busy
  assert_gapless_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bitDone && lastBit && holdFull) |=> (busy && tickCnt == '0));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfgEightBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              holdEmpty,
  output logic              txEnd,
  output logic              txOut
);
  txStrobe_t strobe;
  logic      holdFull;
  logic      lastBit;
  logic      busy;

  serial_frame_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .holdFull(holdFull),
    .lastBit(lastBit), .strobe(strobe), .busy(busy)
  );

  serial_frame_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .cfgEightBits(cfgEightBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .strobe(strobe), .holdFull(holdFull), .lastBit(lastBit), .txOut(txOut)
  );

  assign holdEmpty = !holdFull;
  assign txEnd     = !busy && !holdFull;

  // R1: the line rests high outside a frame
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txOut);
  // R9: the end flag never shows while a bit is on the line low
  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txEnd |-> txOut);
endmodule

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic cfgEightBits = 1'b1, cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic holdEmpty, txEnd, txOut;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .cfgEightBits(cfgEightBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .wrEn(wrEn), .wrData(wrData),
    .holdEmpty(holdEmpty), .txEnd(txEnd), .txOut(txOut)
  );

  // 16x enable every second clock
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tick16 <= ~tick16;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic getSample(output logic s);
    do @(negedge clk); while (!tick16);
    s = txOut;
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // check one frame tick by tick
  task automatic expectFrame(input logic [7:0] d, input bit e8, input bit pe,
                             input bit po, input bit two, input bit immediate);
    logic exp [12];
    string tag [12];
    int n = 0;
    int nd = e8 ? 8 : 7;
    logic par = po;
    logic s;
    int guard = 0;
    exp[n] = 1'b0; tag[n] = "R2 start"; n++;
    for (int i = 0; i < nd; i++) begin
      exp[n] = d[i]; tag[n] = "R3 data"; n++;
      par = par ^ d[i];
    end
    if (pe) begin exp[n] = par; tag[n] = "R4 parity"; n++; end
    exp[n] = 1'b1; tag[n] = "R5 stop"; n++;
    if (two) begin exp[n] = 1'b1; tag[n] = "R5 stop2"; n++; end
    getSample(s);
    if (immediate) begin
      check(s == 1'b0, "R8 gapless start", int'(s), 0);
    end else begin
      while (s == 1'b1 && guard < 100) begin getSample(s); guard++; end
    end
    check(txEnd == 1'b0, "R9 txEnd low in frame", int'(txEnd), 0);
    for (int b = 0; b < n; b++) begin
      int bad = 0;
      int got = 0;
      for (int k = 0; k < 16; k++) begin
        if (!(b == 0 && k == 0)) getSample(s);
        if (s != exp[b]) bad++;
        got = int'(s);
      end
      check(bad == 0, $sformatf("%s bit %0d (R2 width)", tag[b], b), got, int'(exp[b]));
    end
  endtask

  task automatic setCfg(input int c);
    cfgEightBits = c[0]; cfgParityEn = c[1]; cfgParityOdd = c[2]; cfgTwoStop = c[3];
  endtask

  task automatic expectIdle(input int nTicks);
    logic s;
    int bad = 0;
    @(negedge clk);
    check(txEnd == 1'b1 && holdEmpty == 1'b1, "R9 txEnd after frame", int'(txEnd), 1);
    for (int k = 0; k < nTicks; k++) begin
      getSample(s);
      if (s != 1'b1) bad++;
    end
    check(bad == 0, "R1/R7 line idle high", bad, 0);
  endtask

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
    repeat (3) @(negedge clk);
    check(txOut == 1'b1, "R1 reset txOut", int'(txOut), 1);
    check(holdEmpty == 1'b1, "R1 reset holdEmpty", int'(holdEmpty), 1);
    check(txEnd == 1'b1, "R1 reset txEnd", int'(txEnd), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: flag timing on a single write while idle
    setCfg(1);
    fork
      begin
        writeChar(8'h3C);
        check(holdEmpty == 1'b0, "R6 holdEmpty clears", int'(holdEmpty), 0);
        @(negedge clk);
        check(holdEmpty == 1'b1, "R6 holdEmpty after load", int'(holdEmpty), 1);
      end
      expectFrame(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    join
    expectIdle(4);

    // sweep: all configurations, several patterns (R3 R4 R5)
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 6; p++) begin
        logic [7:0] d = pats[p] ^ 8'(c * 37);
        setCfg(c);
        fork
          writeChar(d);
          expectFrame(d, c[0], c[1], c[2], c[3], 1'b0);
        join
        expectIdle(2);
      end
    end

    // R8 R10 R7: back-to-back with config change and ignored write
    setCfg(4'b0011);
    fork
      begin
        writeChar(8'hC3);
        while (!holdEmpty) @(negedge clk);
        setCfg(4'b1110);
        writeChar(8'h96);
        check(holdEmpty == 1'b0, "R6 holdEmpty while busy", int'(holdEmpty), 0);
        writeChar(8'h00);
        check(holdEmpty == 1'b0, "R7 full after ignored write", int'(holdEmpty), 0);
      end
      begin
        expectFrame(8'hC3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expectFrame(8'h96, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R10 new cfg
      end
    join
    expectIdle(40);

    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule